// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Array Model

This block is a cycle-counted, synthesizable model of a 64K x 1 dynamic memory. The cells form a 256 x 256 array that is reached through a single 8-bit address bus. The row half of the address is taken when the row strobe falls. The column half is taken when the column strobe falls. Opening a row copies all of its bits into a bank of column latches and leaves the cells of that row empty. Column accesses then read or modify single latches. Raising the row strobe writes the whole latched row back into the array.

The model also tracks charge retention. Each row keeps an age in clock cycles. A row that is not opened within the retention limit loses its data, and it reads as zero the next time it is opened. Any row opening restores that row's age, including a row-strobe-only cycle with no column access. Several column strobes may follow one row strobe (page mode). A column strobe that arrives with no row open is flagged as a protocol error and has no effect on the data.

All strobes are active low and are sampled on the rising clock edge. Edges are detected against the value sampled one cycle earlier.

Top module: `dram_mux_array`

## Requirements
- R1: The row address is the value of `addr` at the clock edge where a fall of `ras_n` is seen, and the column address is the value of `addr` where a fall of `cas_n` is seen. Cell (row r, column c) is distinct from cell (row c, column r) when r differs from c.
- R2: On a column access with `rw_n`=1, `dout` shows the latched bit of the selected column from the cycle after the edge that sampled the column strobe fall, and holds it while `cas_n` stays low.
- R3: On a column access with `rw_n`=0, `din` is loaded into the selected column latch. The new value is returned by later reads of the same open row and survives the write-back.
- R4: Page mode: any number of column strobes may follow one row strobe fall, and each one reads or writes another bit of the same open row.
- R5: Opening a row clears its cells while it is open. Raising `ras_n` writes the full latched row back, so a reopened row returns the data it held at close.
- R6: `dout` is 0 whenever no column read is in progress: after `cas_n` has been sampled high, and during column writes.
- R7: A fall of `cas_n` while no row is open raises `proto_err` for exactly one cycle. It changes no stored bit and leaves `dout` at 0.
- R8: A row that is not opened for more than `RETAIN_CYC` clock cycles loses its data and reads back as all zeros when it is next opened.
- R9: A row-strobe-only cycle (row strobe fall and rise with no column strobe) refreshes the addressed row, so its data survives spans longer than `RETAIN_CYC` as long as each gap between refreshes is shorter than the limit.
- R10: After reset every cell reads 0, `dout` is 0 and `proto_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| rw_n | input | 1 | Access type sampled at the column strobe fall: 1 read, 0 write |
| addr | input | ADDR_W (8) | Multiplexed address: row half, then column half |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit; 0 when no read is in progress |
| proto_err | output | 1 | One-cycle pulse for a column strobe with no open row |

## Verification
A wrong internal state only appears at `dout`, and only when the affected cell is read. A latch that is loaded wrongly shows up on the next read of the same column in the open page, one cycle after that strobe. A missed or corrupted write-back stays hidden until the row is opened again and the damaged column is read. A retention counter that fires too early or too late shows up only after many thousands of idle cycles, as a zero or as a surviving bit. For this reason the bench mixes short read-after-write pages with long idle spans in which one row is refreshed and another is left to expire.

// File: rtl/dram_mux_pkg.sv
// Shared types for the multiplexed-address dynamic memory model.
// Assumes single-clock use; events are one-cycle pulses.
package dram_mux_pkg;

    // Strobe events decoded for one clock edge.
    typedef struct packed {
        logic open_row;   // row strobe fall seen: capture and read out a row
        logic close_row;  // row strobe rise while open: write the row back
        logic col_start;  // valid column strobe fall inside an open row
        logic col_write;  // that column access is a write
    } dram_evt_t;

endpackage

// File: rtl/dram_strobe_ctl.sv
// Strobe decoder: finds strobe edges, holds the open row and column
// addresses, and flags column strobes that arrive with no open row.
// Assumes the strobes are already synchronous to clk.
module dram_strobe_ctl
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              rw_n,
    input  logic [ADDR_W-1:0] addr,
    output dram_evt_t         evt_o,
    output logic              row_open_o,
    output logic [ADDR_W-1:0] row_o,
    output logic [ADDR_W-1:0] col_o,
    output logic              col_act_o,
    output logic              col_rd_o,
    output logic              proto_err_o
);

    logic ras_q, cas_q;
    logic ras_fall, ras_rise, cas_fall, col_ok;

    // Decode the events for this edge from current and last strobe values.
    always_comb begin
        ras_fall = ras_q & ~ras_n;
        ras_rise = row_open_o & ras_n;
        cas_fall = cas_q & ~cas_n;
        col_ok   = cas_fall & row_open_o & ~ras_n;
        evt_o.open_row  = ras_fall;
        evt_o.close_row = ras_rise;
        evt_o.col_start = col_ok;
        evt_o.col_write = col_ok & ~rw_n;
    end

    // Keep the strobe history that edge detection compares against.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    // Track the open row and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open_o <= 1'b0;
            row_o      <= '0;
        end else if (ras_fall) begin
            row_open_o <= 1'b1;
            row_o      <= addr;
        end else if (ras_rise) begin
            row_open_o <= 1'b0;
        end
    end

    // Track the column access in progress and its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_act_o <= 1'b0;
            col_rd_o  <= 1'b0;
            col_o     <= '0;
        end else if (col_ok) begin
            col_act_o <= 1'b1;
            col_rd_o  <= rw_n;
            col_o     <= addr;
        end else if (cas_n || ras_n) begin
            col_act_o <= 1'b0;
        end
    end

    // Pulse the error flag for a column strobe outside an open row.
    always_ff @(posedge clk) begin
        if (!rst_n) proto_err_o <= 1'b0;
        else        proto_err_o <= cas_fall & ~(row_open_o & ~ras_n);
    end

    AST_ROW_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        row_open_o && $past(row_open_o) |-> $stable(row_o)); // R1
    AST_COL_INSIDE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        col_act_o |-> row_open_o); // R4
    AST_ERR_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> $past(!cas_n)); // R7
    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> !col_act_o); // R7

endmodule

// File: rtl/dram_retention.sv
// Per-row retention tracker: each row ages by one per cycle while it is
// closed and still holds data. It loses its data when the age reaches
// RETAIN_CYC. Opening the row, or keeping it open, resets the age.
// Assumes RETAIN_CYC >= 2.
module dram_retention #(
    parameter int ADDR_W     = 8,
    parameter int RETAIN_CYC = 64000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_evt_i,
    input  logic [ADDR_W-1:0] open_addr_i,
    input  logic              row_open_i,
    input  logic [ADDR_W-1:0] cur_row_i,
    output logic [(1<<ADDR_W)-1:0] alive_o
);

    localparam int ROWS  = 1 << ADDR_W;
    localparam int AGE_W = $clog2(RETAIN_CYC + 1);
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(RETAIN_CYC - 1);

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        localparam logic [ADDR_W-1:0] ROW_IDX = ADDR_W'(i);
        logic [AGE_W-1:0] age;
        logic             alive;
        logic             hold;

        assign hold       = (open_evt_i && open_addr_i == ROW_IDX) ||
                            (row_open_i && cur_row_i == ROW_IDX);
        assign alive_o[i] = alive;

        // Age this row, or drop its data when the limit is reached.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age   <= '0;
                alive <= 1'b1;
            end else if (hold) begin
                age   <= '0;
                alive <= 1'b1;
            end else if (alive) begin
                if (age == AGE_LAST) begin
                    age   <= '0;
                    alive <= 1'b0;
                end else begin
                    age <= age + 1'b1;
                end
            end
        end

        AST_AGE_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            alive |-> age < AGE_W'(RETAIN_CYC)); // R8
    end

endmodule

// File: rtl/dram_cell_core.sv
// Cell array and column latches. A row open moves the row into the
// latches and clears its cells. Column writes change one latch. A row
// close stores the latches back. Rows that have lost retention load
// as zeros. Assumes the events come from dram_strobe_ctl.
module dram_cell_core
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  dram_evt_t              evt_i,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   din,
    input  logic [ADDR_W-1:0]      row_i,
    input  logic [ADDR_W-1:0]      col_i,
    input  logic                   row_open_i,
    input  logic [(1<<ADDR_W)-1:0] alive_i,
    output logic                   lat_bit_o
);

    localparam int ROWS = 1 << ADDR_W;
    localparam int COLS = 1 << ADDR_W;

    logic [COLS-1:0] cells [ROWS];
    logic [COLS-1:0] latches;

    assign lat_bit_o = latches[col_i];

    // Move rows between the array and the latches, and apply column writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) cells[r] <= '0;
            latches <= '0;
        end else begin
            if (evt_i.open_row) begin
                latches     <= alive_i[addr] ? cells[addr] : '0;
                cells[addr] <= '0;
            end
            if (evt_i.col_write) latches[addr] <= din;
            if (evt_i.close_row) cells[row_i] <= latches;
        end
    end

    AST_OPEN_ROW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        row_open_i |-> cells[row_i] == '0); // R5

endmodule

// File: rtl/dram_mux_array.sv
// Top of the multiplexed-address dynamic memory model: strobe decoder,
// retention tracker and cell core. dout shows the selected latch only
// while a column read is in progress. Assumes strobes are synchronous.
module dram_mux_array
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int RETAIN_CYC = 64000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              rw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              proto_err
);

    localparam int ROWS = 1 << ADDR_W;

    dram_evt_t         evt;
    logic              row_open, col_act, col_rd, lat_bit;
    logic [ADDR_W-1:0] row_q, col_q;
    logic [ROWS-1:0]   alive;

    dram_strobe_ctl #(.ADDR_W(ADDR_W)) ctl_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .rw_n(rw_n),
        .addr(addr), .evt_o(evt), .row_open_o(row_open), .row_o(row_q),
        .col_o(col_q), .col_act_o(col_act), .col_rd_o(col_rd),
        .proto_err_o(proto_err)
    );

    dram_retention #(.ADDR_W(ADDR_W), .RETAIN_CYC(RETAIN_CYC)) ret_i (
        .clk(clk), .rst_n(rst_n), .open_evt_i(evt.open_row),
        .open_addr_i(addr), .row_open_i(row_open), .cur_row_i(row_q),
        .alive_o(alive)
    );

    dram_cell_core #(.ADDR_W(ADDR_W)) core_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .addr(addr), .din(din),
        .row_i(row_q), .col_i(col_q), .row_open_i(row_open),
        .alive_i(alive), .lat_bit_o(lat_bit)
    );

    // Drive the data pin only during a column read.
    always_comb dout = (col_act && col_rd) ? lat_bit : 1'b0;

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cas_n) |-> !dout); // R6

endmodule

// File: tb/dram_mux_array_tb.sv
// Bench: directed corner cases plus seeded random page traffic, checked
// against a bench-side image of the memory.
module dram_mux_array_tb_top;

    localparam int RET = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, rw_n = 1'b1, din = 1'b0;
    logic [7:0] addr = '0;
    logic       dout, proto_err;

    int  checks = 0;
    int  fails  = 0;
    int  cycles = 0;
    bit  exp_mem [256][256];

    always #5 clk = ~clk;

    dram_mux_array #(.ADDR_W(8), .RETAIN_CYC(RET)) dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .rw_n(rw_n),
        .addr(addr), .din(din), .dout(dout), .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic open_row(input logic [7:0] r);
        ras_n = 1'b0; addr = r; step();
    endtask

    task automatic close_row();
        ras_n = 1'b1; step();
    endtask

    task automatic col_read(input logic [7:0] c, input logic exp, input string req);
        cas_n = 1'b0; rw_n = 1'b1; addr = c; step();
        chk(req, dout, exp);
        step();
        chk(req, dout, exp);          // held while cas_n low (R2)
        cas_n = 1'b1; step();
        chk("R6 idle", dout, 1'b0);
    endtask

    task automatic col_write(input logic [7:0] r, input logic [7:0] c, input logic b);
        cas_n = 1'b0; rw_n = 1'b0; addr = c; din = b; step();
        chk("R6 write", dout, 1'b0);
        exp_mem[r][c] = b;
        cas_n = 1'b1; rw_n = 1'b1; step();
    endtask

    // Watchdog: a hung run counts as a failure and still summarizes.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= 200000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<200000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4242);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        chk("R10 dout", dout, 1'b0);
        chk("R10 err", proto_err, 1'b0);
        open_row(8'd5);
        col_read(8'd9, 1'b0, "R10 cell");
        close_row();

        // R7: column strobe with no row open, write attempt ignored
        cas_n = 1'b0; rw_n = 1'b0; din = 1'b1; addr = 8'd7; step();
        chk("R7 flag", proto_err, 1'b1);
        chk("R7 dout", dout, 1'b0);
        cas_n = 1'b1; rw_n = 1'b1; step();
        chk("R7 pulse", proto_err, 1'b0);

        // R1: row/column halves are distinct
        open_row(8'h12);
        col_write(8'h12, 8'h34, 1'b1);
        close_row();
        open_row(8'h34);
        col_read(8'h12, 1'b0, "R1 swap");
        col_read(8'h07, 1'b0, "R7 nochange");
        close_row();
        open_row(8'h12);
        col_read(8'h34, 1'b1, "R1 addr");
        close_row();

        // R4/R3: page of writes then reads in the same open row
        open_row(8'd3);
        col_write(8'd3, 8'd0, 1'b1);
        col_write(8'd3, 8'd255, 1'b1);
        col_write(8'd3, 8'd128, 1'b1);
        col_write(8'd3, 8'd128, 1'b0);
        col_read(8'd0, 1'b1, "R4 page");
        col_read(8'd255, 1'b1, "R3 same row");
        col_read(8'd128, 1'b0, "R3 overwrite");
        close_row();
        // R5: write-back after close
        open_row(8'd3);
        col_read(8'd255, 1'b1, "R5 writeback");
        col_read(8'd0, 1'b1, "R5 writeback");
        close_row();

        // Random page traffic on rows 0..15
        for (int n = 0; n < 60; n++) begin
            logic [7:0] r;
            int ops;
            r = 8'($urandom % 16);
            ops = 1 + ($urandom % 4);
            open_row(r);
            for (int k = 0; k < ops; k++) begin
                logic [7:0] c;
                c = 8'($urandom);
                if ($urandom % 2) col_write(r, c, 1'($urandom));
                else              col_read(c, exp_mem[r][c], "R2 random");
            end
            close_row();
        end

        // R8/R9: row 200 refreshed by row-only cycles, row 201 left alone
        open_row(8'd200);
        col_write(8'd200, 8'd17, 1'b1);
        close_row();
        open_row(8'd201);
        col_write(8'd201, 8'd17, 1'b1);
        close_row();
        for (int p = 0; p < 4; p++) begin
            repeat (8000) step();
            open_row(8'd200);
            step();
            close_row();
        end
        open_row(8'd200);
        col_read(8'd17, 1'b1, "R9 refresh");
        close_row();
        open_row(8'd201);
        col_read(8'd17, 1'b0, "R8 expired");
        close_row();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule